// File: doc/BRIEF.md
# Cascadable Static LCD Segment Driver

This block drives a directly driven (static) liquid-crystal display with a parameterised number of segment outputs, 40 by default. Display data enters one bit at a time on a serial data pin, timed by a slow external shift clock. The bit leaving the far end of the internal shift chain is presented on a serial data output, so any number of drivers can be chained into one long display. A strobe copies the whole shift chain into a bank of display latches at once. Shifting while the strobe is low leaves the visible pattern untouched.

Every segment pin is driven with AC so the glass never sees a DC bias. An external frame square wave, typically 64 Hz, is XORed with each latched bit. A segment whose latched bit is 0 therefore moves in phase with the frame signal and can act as the backplane. A segment whose bit is 1 moves in antiphase and appears dark. A blanking input puts every output in backplane phase, which clears the display without disturbing the latches.

All external control inputs are asynchronous to the system clock. Each one passes through a synchroniser and a digital deglitcher before any logic uses it. Pulses shorter than a set number of system clocks are discarded.

Top module: `lcdseg_top`

## Requirements
- R1: After reset, every shift stage, every display latch and the serial output are 0, so each segment output equals the filtered frame level.
- R2: On each accepted rising edge of the shift clock, stage 0 takes the serial data input and every stage i > 0 takes the old value of stage i-1. Segment output i reflects stage i. The first bit shifted in ends up at the highest index.
- R3: The serial output changes only on an accepted falling edge of the shift clock. It then takes the value of the highest shift stage, so a bit appears there after as many clocks as there are segments.
- R4: While the filtered strobe is high, the display latches follow the shift chain. While it is low, they hold, and shifting has no effect on the segment outputs.
- R5: With blanking low, segment output i equals the frame level XOR display latch i, so a 1 gives antiphase to the frame and a 0 gives in-phase drive.
- R6: With blanking high, every segment output equals the frame level, whatever the latches hold. The latches keep their contents through blanking.
- R7: A level change on any input that lasts fewer than FILT_LEN system clocks (default 3) after synchronisation is ignored. It causes no shift, no latch update and no change at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial display data |
| strobe_i | input | 1 | Latch enable, transparent while high |
| frame_i | input | 1 | Frame square wave setting drive polarity |
| blank_i | input | 1 | Forces all outputs to backplane phase |
| sdata_o | output | 1 | Cascade data output |
| seg_o | output | NSEG | Segment drive outputs |

## Verification
The hardest case to reach from the ports is proving that the latches hold while a complete new pattern passes through the shift chain. The bench first strobes one random pattern into the latches. It then shifts a different full-length pattern with the strobe low and checks the segments under both frame polarities. Finally it strobes, so the hidden second pattern becomes visible and can be compared against its own reference model. Short pulses on the shift clock and on blanking are also injected. Their rejection is confirmed both at the outputs and through the contents of the chain once a later strobe exposes them.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
    // index of each control input inside the filter bank
    localparam int unsigned IN_SCLK  = 0;
    localparam int unsigned IN_SDATA = 1;
    localparam int unsigned IN_STB   = 2;
    localparam int unsigned IN_FRAME = 3;
    localparam int unsigned IN_BLANK = 4;
    localparam int unsigned N_IN     = 5;
endpackage

// File: rtl/lcdseg_deglitch.sv
module lcdseg_deglitch #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   level;
    } filt_t;

    filt_t st_d, st_q;
    logic  smp;

    assign smp = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw_i};
        if (smp == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(FILT_LEN - 1)) begin
            st_d.level = smp;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clean_o = st_q.level;
endmodule

// File: rtl/lcdseg_shifter.sv
module lcdseg_shifter #(
    parameter int unsigned NSEG = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_f,
    input  logic            sdata_f,
    output logic [NSEG-1:0] chain_o,
    output logic            sout_o
);
    typedef struct packed {
        logic            sclk_prev;
        logic [NSEG-1:0] chain;
        logic            sout;
    } sh_t;

    sh_t  st_d, st_q;
    logic rise, fall;

    assign rise = sclk_f & ~st_q.sclk_prev;
    assign fall = ~sclk_f & st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_f;
        if (rise) st_d.chain = {st_q.chain[NSEG-2:0], sdata_f};
        if (fall) st_d.sout  = st_q.chain[NSEG-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chain_o = st_q.chain;
    assign sout_o  = st_q.sout;
endmodule

// File: rtl/lcdseg_drive.sv
module lcdseg_drive #(
    parameter int unsigned NSEG = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSEG-1:0] chain_i,
    input  logic            stb_f,
    input  logic            frame_f,
    input  logic            blank_f,
    output logic [NSEG-1:0] latch_o,
    output logic [NSEG-1:0] seg_o
);
    typedef struct packed {
        logic [NSEG-1:0] latch;
        logic [NSEG-1:0] seg;
    } drv_t;

    drv_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb_f) st_d.latch = chain_i;
        for (int i = 0; i < int'(NSEG); i++) begin
            st_d.seg[i] = blank_f ? frame_f : (frame_f ^ st_q.latch[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o = st_q.latch;
    assign seg_o   = st_q.seg;
endmodule

// File: rtl/lcdseg_top.sv
module lcdseg_top #(
    parameter int unsigned NSEG        = 40,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_i,
    input  logic            sdata_i,
    input  logic            strobe_i,
    input  logic            frame_i,
    input  logic            blank_i,
    output logic            sdata_o,
    output logic [NSEG-1:0] seg_o
);
    import lcdseg_pkg::*;

    logic [N_IN-1:0] raw_in, flt;
    logic            sclk_f, sdata_f, stb_f, frame_f, blank_f;
    logic [NSEG-1:0] chain, latch;

    assign raw_in[IN_SCLK]  = sclk_i;
    assign raw_in[IN_SDATA] = sdata_i;
    assign raw_in[IN_STB]   = strobe_i;
    assign raw_in[IN_FRAME] = frame_i;
    assign raw_in[IN_BLANK] = blank_i;

    for (genvar g = 0; g < int'(N_IN); g++) begin : g_filt
        lcdseg_deglitch #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_in[g]),
            .clean_o(flt[g])
        );
    end

    assign sclk_f  = flt[IN_SCLK];
    assign sdata_f = flt[IN_SDATA];
    assign stb_f   = flt[IN_STB];
    assign frame_f = flt[IN_FRAME];
    assign blank_f = flt[IN_BLANK];

    lcdseg_shifter #(.NSEG(NSEG)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_f (sclk_f),
        .sdata_f(sdata_f),
        .chain_o(chain),
        .sout_o (sdata_o)
    );

    lcdseg_drive #(.NSEG(NSEG)) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .chain_i(chain),
        .stb_f  (stb_f),
        .frame_f(frame_f),
        .blank_f(blank_f),
        .latch_o(latch),
        .seg_o  (seg_o)
    );
endmodule

// File: rtl/lcdseg_checker.sv
module lcdseg_checker #(
    parameter int unsigned NSEG = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sclk_f,
    input logic            sdata_f,
    input logic            stb_f,
    input logic            frame_f,
    input logic            blank_f,
    input logic [NSEG-1:0] chain,
    input logic [NSEG-1:0] latch,
    input logic [NSEG-1:0] seg,
    input logic            sout
);
    // R1: state right after reset release
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (chain == '0 && latch == '0 && sout == 1'b0));

    // R2: one-place shift on a filtered rising edge
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_f && !$past(sclk_f)) |=>
            chain == {$past(chain[NSEG-2:0]), $past(sdata_f)});

    // R3: cascade output moves only on falling edges
    a_r3_sout_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_f && $past(sclk_f)) |=> sout == $past(chain[NSEG-1]));
    a_r3_sout_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sclk_f && $past(sclk_f)) |=> $stable(sout));

    // R4: latches transparent while strobe is high, hold while low
    a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        stb_f |=> latch == $past(chain));
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_f |=> $stable(latch));

    // R5: segment drive is frame XOR latch
    a_r5_xor_rule: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_f |=> seg == ({NSEG{$past(frame_f)}} ^ $past(latch)));

    // R6: blanking forces backplane phase
    a_r6_blank_phase: assert property (@(posedge clk) disable iff (!rst_n)
        blank_f |=> seg == {NSEG{$past(frame_f)}});
endmodule

bind lcdseg_top lcdseg_checker #(.NSEG(NSEG)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_f (sclk_f),
    .sdata_f(sdata_f),
    .stb_f  (stb_f),
    .frame_f(frame_f),
    .blank_f(blank_f),
    .chain  (chain),
    .latch  (latch),
    .seg    (seg_o),
    .sout   (sdata_o)
);

// File: tb/lcdseg_top_tb.sv
module lcdseg_top_tb;
    localparam int NSEG   = 40;
    localparam int SETTLE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, stb = 1'b0, frame = 1'b0, blank = 1'b0;
    logic            sout;
    logic [NSEG-1:0] seg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [NSEG-1:0] m_chain = '0;
    logic [NSEG-1:0] m_latch = '0;

    always #10 clk = ~clk;

    lcdseg_top #(.NSEG(NSEG)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk),
        .sdata_i (sdata),
        .strobe_i(stb),
        .frame_i (frame),
        .blank_i (blank),
        .sdata_o (sout),
        .seg_o   (seg)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic [NSEG-1:0] act,
                       input logic [NSEG-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one shift-clock period; returns after the falling edge has settled
    task automatic shift_bit(input logic b);
        sdata = b;
        cyc(SETTLE);
        sclk = 1'b1;
        cyc(SETTLE);
        m_chain = {m_chain[NSEG-2:0], b};
        sclk = 1'b0;
        cyc(SETTLE);
    endtask

    task automatic pulse_strobe();
        stb = 1'b1;
        cyc(SETTLE);
        stb = 1'b0;
        cyc(SETTLE);
        m_latch = m_chain;
    endtask

    function automatic logic [NSEG-1:0] rand_pat();
        return NSEG'({$urandom(), $urandom()});
    endfunction

    task automatic t_reset();
        chk("R1 seg after reset", seg, '0);
        chk("R1 sout after reset", {{(NSEG-1){1'b0}}, sout}, '0);
        frame = 1'b1;
        cyc(SETTLE);
        chk("R1 seg follows frame", seg, '1);
        frame = 1'b0;
        cyc(SETTLE);
    endtask

    // R2/R3: the cascade output delivers each bit one full chain later
    task automatic t_cascade(input int nbits);
        for (int k = 0; k < nbits; k++) begin
            shift_bit(1'($urandom()));
            chk("R3 cascade output", {{(NSEG-1){1'b0}}, sout},
                {{(NSEG-1){1'b0}}, m_chain[NSEG-1]});
        end
    endtask

    task automatic load_pattern(input logic [NSEG-1:0] p);
        for (int k = NSEG - 1; k >= 0; k--) shift_bit(p[k]);
    endtask

    task automatic t_strobe_xor();
        logic [NSEG-1:0] p = rand_pat();
        load_pattern(p);
        chk("R2 chain equals pattern", m_chain, p);
        pulse_strobe();
        chk("R5 frame low", seg, p);
        frame = 1'b1;
        cyc(SETTLE);
        chk("R5 frame high", seg, ~p);
        frame = 1'b0;
        cyc(SETTLE);
    endtask

    task automatic t_hold();
        logic [NSEG-1:0] shown = m_latch;
        logic [NSEG-1:0] hidden = rand_pat() ^ shown;
        load_pattern(hidden);
        chk("R4 hold, frame low", seg, shown);
        frame = 1'b1;
        cyc(SETTLE);
        chk("R4 hold, frame high", seg, ~shown);
        pulse_strobe();
        chk("R4 new pattern after strobe", seg, ~hidden);
        frame = 1'b0;
        cyc(SETTLE);
    endtask

    task automatic t_blank();
        logic [NSEG-1:0] keep = m_latch;
        blank = 1'b1;
        cyc(SETTLE);
        chk("R6 blank frame low", seg, '0);
        frame = 1'b1;
        cyc(SETTLE);
        chk("R6 blank frame high", seg, '1);
        blank = 1'b0;
        cyc(SETTLE);
        chk("R6 latches kept", seg, ~keep);
        frame = 1'b0;
        cyc(SETTLE);
    endtask

    task automatic t_glitch();
        logic [NSEG-1:0] keep = m_latch;
        // 2-clock pulse on blanking: must not reach the outputs
        blank = 1'b1;
        cyc(2);
        blank = 1'b0;
        for (int k = 0; k < SETTLE; k++) begin
            cyc(1);
            chk("R7 blank glitch", seg, keep);
        end
        // 2-clock pulses on the shift clock: no shift
        for (int k = 0; k < 4; k++) begin
            sdata = 1'b1;
            sclk = 1'b1;
            cyc(2);
            sclk = 1'b0;
            cyc(SETTLE);
        end
        sdata = 1'b0;
        cyc(SETTLE);
        pulse_strobe();
        chk("R7 sclk glitch did not shift", seg, m_chain);
        // 2-clock strobe glitch: latches unchanged
        keep = m_latch;
        shift_bit(~m_chain[0]);
        stb = 1'b1;
        cyc(2);
        stb = 1'b0;
        cyc(SETTLE);
        chk("R7 strobe glitch", seg, keep);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(SETTLE);
        t_reset();
        t_cascade(2 * NSEG);
        t_strobe_xor();
        t_hold();
        t_blank();
        t_glitch();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end
endmodule